// File: doc/BRIEF.md
# Event Code Mapping Decoder

This block turns each received 8-bit timing event code into a set of one-cycle strobes. Each of the 256 event codes owns one 128-bit mapping word. Every bit of that word drives exactly one destination: a fixed system function, or a trigger, set or clear action of one pulse generator. When a valid event arrives, the block reads the word for that code. In the following cycle it drives the strobes the word selects, minus the bits that are reserved or that point at generators this instance does not build.

Software fills the table through a register write port, one 32-bit lane of one entry per cycle. Reset loads a default table. In that table the special system codes already select their functions and every other bit is clear, so a receiver that has just been reset already handles timestamping, heartbeat and prescaler reset. The number of pulse generators and the write lane width are parameters.

Top module: `evmap_decoder`

## Requirements
- R1: After reset every entry is zero except these defaults: code 0x79 sets bit 123, code 0x7A sets bit 101, code 0x7B sets bit 100, code 0x7D sets bit 99, code 0x7C sets bit 98, code 0x71 sets bit 97, and code 0x70 sets bit 96.
- R2: A lookup with `ev_valid` high at a clock edge drives its strobes for exactly the one cycle after that edge. Back-to-back lookups give one strobe cycle each.
- R3: Fixed function bits map to these ports: bit 127 `fifo_save`, bit 126 `ts_latch`, bit 125 `led_flash`, bit 124 `fwd_up`, bit 123 `fifo_stop`, bit 101 `heartbeat`, bit 100 `presc_rst`, bit 99 `ts_reset`, bit 98 `ts_clock`, bit 97 `sec_one`, bit 96 `sec_zero`.
- R4: Bit g of the entry drives `pulse_trig[g]`, bit 32+g drives `pulse_set[g]`, and bit 64+g drives `pulse_clr[g]`, for every g below PULSE_GENS. Bits for generators at or above PULSE_GENS produce nothing.
- R5: Bits 102 to 122 produce no strobe on any port, even when they are set.
- R6: Event code 0 never produces a strobe, whatever its entry holds.
- R7: A write with `wr_en` high replaces lane `wr_lane` of entry `wr_code`. Lane k is bits 32k+31 down to 32k. The other lanes of that entry and all other entries keep their contents.
- R8: A lookup in the same cycle as a write to its own entry uses the contents from before the write. Later lookups see the new contents.
- R9: With `ev_valid` low, every strobe stays low in the next cycle, whatever `ev_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the default table |
| ev_valid | input | 1 | A received event is present on ev_code |
| ev_code | input | 8 | Received event code |
| wr_en | input | 1 | Table lane write strobe |
| wr_code | input | 8 | Entry to write |
| wr_lane | input | 2 | 32-bit lane of the entry to write |
| wr_data | input | 32 | Lane write data |
| fifo_save | output | 1 | Save event into the event FIFO |
| ts_latch | output | 1 | Latch timestamp |
| led_flash | output | 1 | Flash the event indicator |
| fwd_up | output | 1 | Forward event upstream |
| fifo_stop | output | 1 | Stop the event FIFO |
| heartbeat | output | 1 | Heartbeat seen |
| presc_rst | output | 1 | Reset prescalers |
| ts_reset | output | 1 | Reset timestamp |
| ts_clock | output | 1 | Timestamp clock tick |
| sec_one | output | 1 | Shift a one into the seconds register |
| sec_zero | output | 1 | Shift a zero into the seconds register |
| pulse_trig | output | PULSE_GENS | Per-generator trigger strobes |
| pulse_set | output | PULSE_GENS | Per-generator set strobes |
| pulse_clr | output | PULSE_GENS | Per-generator clear strobes |

## Verification
The lookup is tried in several ways. Walking every default code tells a correctly preloaded table from one with shifted or missing defaults. Entries written all ones expose any reserved bit or any generator above PULSE_GENS that leaks through. Single-lane patterns tell one lane apart from its neighbours and catch a swapped trigger, set or clear group. A write and a lookup to the same entry in one cycle show whether old or new data is used. Code 0 and held-low `ev_valid` show whether the qualifiers gate the output. A long random mix of writes and lookups, checked against a bench copy of the table, catches ordering errors across back-to-back cycles.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
   localparam int CODE_W  = 8;
   localparam int ENTRIES = 1 << CODE_W;
   localparam int GROUP_W = 32;
   localparam int ENTRY_W = 4 * GROUP_W;

   // fixed function bit positions
   localparam int B_FIFO_SAVE = 127;
   localparam int B_TS_LATCH  = 126;
   localparam int B_LED       = 125;
   localparam int B_FWD       = 124;
   localparam int B_FIFO_STOP = 123;
   localparam int B_RSV_HI    = 122;
   localparam int B_RSV_LO    = 102;
   localparam int B_HEARTBEAT = 101;
   localparam int B_PRESC_RST = 100;
   localparam int B_TS_RESET  = 99;
   localparam int B_TS_CLOCK  = 98;
   localparam int B_SEC_ONE   = 97;
   localparam int B_SEC_ZERO  = 96;

   localparam int TRIG_BASE = 0;
   localparam int SET_BASE  = GROUP_W;
   localparam int CLR_BASE  = 2 * GROUP_W;

   function automatic logic [ENTRY_W-1:0] default_entry(input logic [CODE_W-1:0] code);
      logic [ENTRY_W-1:0] e;
      e = '0;
      case (code)
         8'h79:   e[B_FIFO_STOP] = 1'b1;
         8'h7A:   e[B_HEARTBEAT] = 1'b1;
         8'h7B:   e[B_PRESC_RST] = 1'b1;
         8'h7D:   e[B_TS_RESET]  = 1'b1;
         8'h7C:   e[B_TS_CLOCK]  = 1'b1;
         8'h71:   e[B_SEC_ONE]   = 1'b1;
         8'h70:   e[B_SEC_ZERO]  = 1'b1;
         default: e = '0;
      endcase
      return e;
   endfunction

   // bits that may reach a port for a given generator count
   function automatic logic [ENTRY_W-1:0] keep_mask(input int gens);
      logic [ENTRY_W-1:0] m;
      m = '0;
      for (int b = B_FIFO_STOP; b <= B_FIFO_SAVE; b++) m[b] = 1'b1;
      for (int b = B_SEC_ZERO; b <= B_HEARTBEAT; b++) m[b] = 1'b1;
      for (int g = 0; g < GROUP_W; g++) begin
         if (g < gens) begin
            m[TRIG_BASE + g] = 1'b1;
            m[SET_BASE + g]  = 1'b1;
            m[CLR_BASE + g]  = 1'b1;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/evmap_table.sv
module evmap_table
   import evmap_pkg::*;
#(
   parameter int LANE_W = 32,
   localparam int LANES = ENTRY_W / LANE_W,
   localparam int SEL_W = $clog2(LANES)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CODE_W-1:0]   wr_code,
   input  logic [SEL_W-1:0]    wr_lane,
   input  logic [LANE_W-1:0]   wr_data,
   input  logic [CODE_W-1:0]   rd_code,
   output logic [ENTRY_W-1:0]  rd_word
);
   logic [ENTRY_W-1:0] mem_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem_q[i] <= default_entry(CODE_W'(i));
      end else if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_lane == SEL_W'(l)) mem_q[wr_code][l*LANE_W +: LANE_W] <= wr_data;
         end
      end
   end

   // asynchronous read: the registered strobe stage sees pre-write contents
   assign rd_word = mem_q[rd_code];

   // write tracking for the lane check
   logic              chk_vld;
   logic [CODE_W-1:0] chk_code;
   logic [SEL_W-1:0]  chk_lane;
   logic [LANE_W-1:0] chk_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld  <= 1'b0;
         chk_code <= '0;
         chk_lane <= '0;
         chk_data <= '0;
      end else begin
         chk_vld  <= wr_en;
         chk_code <= wr_code;
         chk_lane <= wr_lane;
         chk_data <= wr_data;
      end
   end

   function automatic logic [LANE_W-1:0] lane_of(input logic [ENTRY_W-1:0] e,
                                                 input logic [SEL_W-1:0] s);
      logic [LANE_W-1:0] r;
      r = '0;
      for (int l = 0; l < LANES; l++) if (s == SEL_W'(l)) r = e[l*LANE_W +: LANE_W];
      return r;
   endfunction

   assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld |-> (lane_of(mem_q[chk_code], chk_lane) == chk_data));
endmodule

// File: rtl/evmap_strobe.sv
module evmap_strobe
   import evmap_pkg::*;
#(
   parameter int PULSE_GENS = 24
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ev_valid,
   input  logic [CODE_W-1:0]   ev_code,
   input  logic [ENTRY_W-1:0]  rd_word,
   output logic [ENTRY_W-1:0]  hit_q
);
   localparam logic [ENTRY_W-1:0] KEEP = keep_mask(PULSE_GENS);

   logic fire;
   assign fire = ev_valid && (ev_code != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= '0;
      else        hit_q <= fire ? (rd_word & KEEP) : '0;
   end

   assert_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_q) |-> $past(ev_valid));
   assert_code0_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_valid && ev_code == '0) |-> (hit_q == '0));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ev_valid) |-> (hit_q == '0));
   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q[B_RSV_HI:B_RSV_LO] == '0);
endmodule

// File: rtl/evmap_decoder.sv
module evmap_decoder
   import evmap_pkg::*;
#(
   parameter int PULSE_GENS = 24,
   parameter int LANE_W     = 32,
   localparam int LANES     = ENTRY_W / LANE_W,
   localparam int SEL_W     = $clog2(LANES)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ev_valid,
   input  logic [CODE_W-1:0]     ev_code,
   input  logic                  wr_en,
   input  logic [CODE_W-1:0]     wr_code,
   input  logic [SEL_W-1:0]      wr_lane,
   input  logic [LANE_W-1:0]     wr_data,
   output logic                  fifo_save,
   output logic                  ts_latch,
   output logic                  led_flash,
   output logic                  fwd_up,
   output logic                  fifo_stop,
   output logic                  heartbeat,
   output logic                  presc_rst,
   output logic                  ts_reset,
   output logic                  ts_clock,
   output logic                  sec_one,
   output logic                  sec_zero,
   output logic [PULSE_GENS-1:0] pulse_trig,
   output logic [PULSE_GENS-1:0] pulse_set,
   output logic [PULSE_GENS-1:0] pulse_clr
);
   if (PULSE_GENS < 1 || PULSE_GENS > GROUP_W) begin : g_bad_gens
      $error("PULSE_GENS must lie in 1..%0d", GROUP_W);
   end
   if (LANES < 2 || LANES * LANE_W != ENTRY_W) begin : g_bad_lane
      $error("LANE_W must split the entry into at least two equal lanes");
   end

   logic [ENTRY_W-1:0] rd_word;
   logic [ENTRY_W-1:0] hit_q;

   evmap_table #(.LANE_W(LANE_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_code (wr_code),
      .wr_lane (wr_lane),
      .wr_data (wr_data),
      .rd_code (ev_code),
      .rd_word (rd_word)
   );

   evmap_strobe #(.PULSE_GENS(PULSE_GENS)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_valid),
      .ev_code  (ev_code),
      .rd_word  (rd_word),
      .hit_q    (hit_q)
   );

   assign fifo_save = hit_q[B_FIFO_SAVE];
   assign ts_latch  = hit_q[B_TS_LATCH];
   assign led_flash = hit_q[B_LED];
   assign fwd_up    = hit_q[B_FWD];
   assign fifo_stop = hit_q[B_FIFO_STOP];
   assign heartbeat = hit_q[B_HEARTBEAT];
   assign presc_rst = hit_q[B_PRESC_RST];
   assign ts_reset  = hit_q[B_TS_RESET];
   assign ts_clock  = hit_q[B_TS_CLOCK];
   assign sec_one   = hit_q[B_SEC_ONE];
   assign sec_zero  = hit_q[B_SEC_ZERO];

   for (genvar g = 0; g < PULSE_GENS; g++) begin : g_gen
      assign pulse_trig[g] = hit_q[TRIG_BASE + g];
      assign pulse_set[g]  = hit_q[SET_BASE + g];
      assign pulse_clr[g]  = hit_q[CLR_BASE + g];
   end

   // one-cycle strobes: a strobe never repeats without a fresh valid lookup
   assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (heartbeat && !$past(ev_valid)) |-> 1'b0);
endmodule

// File: tb/evmap_decoder_test.sv
module evmap_decoder_test;
   localparam int PG = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_valid = 1'b0;
   logic [7:0] ev_code = '0;
   logic wr_en = 1'b0;
   logic [7:0] wr_code = '0;
   logic [1:0] wr_lane = '0;
   logic [31:0] wr_data = '0;
   logic fifo_save, ts_latch, led_flash, fwd_up, fifo_stop, heartbeat;
   logic presc_rst, ts_reset, ts_clock, sec_one, sec_zero;
   logic [PG-1:0] pulse_trig, pulse_set, pulse_clr;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [127:0] ref_mem [256];

   always #10 clk = ~clk;

   evmap_decoder #(.PULSE_GENS(PG), .LANE_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
      .wr_en(wr_en), .wr_code(wr_code), .wr_lane(wr_lane), .wr_data(wr_data),
      .fifo_save(fifo_save), .ts_latch(ts_latch), .led_flash(led_flash),
      .fwd_up(fwd_up), .fifo_stop(fifo_stop), .heartbeat(heartbeat),
      .presc_rst(presc_rst), .ts_reset(ts_reset), .ts_clock(ts_clock),
      .sec_one(sec_one), .sec_zero(sec_zero),
      .pulse_trig(pulse_trig), .pulse_set(pulse_set), .pulse_clr(pulse_clr));

   function automatic logic [127:0] init_word(input int c);
      logic [127:0] w = '0;
      if (c == 'h70) w[96]  = 1'b1;
      if (c == 'h71) w[97]  = 1'b1;
      if (c == 'h7C) w[98]  = 1'b1;
      if (c == 'h7D) w[99]  = 1'b1;
      if (c == 'h7B) w[100] = 1'b1;
      if (c == 'h7A) w[101] = 1'b1;
      if (c == 'h79) w[123] = 1'b1;
      return w;
   endfunction

   function automatic logic [10:0] exp_fixed(input logic [127:0] e);
      return {e[127:123], e[101:96]};
   endfunction

   function automatic logic [3*PG-1:0] exp_pulse(input logic [127:0] e);
      return {e[64 +: PG], e[32 +: PG], e[0 +: PG]};
   endfunction

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive one cycle, then compare outputs one cycle later
   task automatic step(input string tag, input bit v, input logic [7:0] c,
                       input bit we, input logic [7:0] wc, input logic [1:0] wl,
                       input logic [31:0] wd);
      logic [127:0] e;
      ev_valid = v; ev_code = c;
      wr_en = we; wr_code = wc; wr_lane = wl; wr_data = wd;
      e = (v && c != 8'h00) ? ref_mem[c] : '0;   // old contents (R8)
      if (we) ref_mem[wc][wl*32 +: 32] = wd;
      @(posedge clk);
      @(negedge clk);
      ev_valid = 1'b0; wr_en = 1'b0;
      check({tag, " fixed"},
            128'({fifo_save, ts_latch, led_flash, fwd_up, fifo_stop, heartbeat,
                  presc_rst, ts_reset, ts_clock, sec_one, sec_zero}),
            128'(exp_fixed(e)));
      check({tag, " pulse"}, 128'({pulse_clr, pulse_set, pulse_trig}), 128'(exp_pulse(e)));
   endtask

   task automatic wr(input logic [7:0] wc, input logic [1:0] wl, input logic [31:0] wd);
      step("R7 write", 1'b0, 8'h00, 1'b1, wc, wl, wd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: outputs quiet (R9)
      check("R9 reset quiet", 128'({fifo_save, heartbeat, sec_zero, pulse_trig}), '0);

      // R1: every code against the default table
      for (int c = 0; c < 256; c++) step("R1 default", 1'b1, 8'(c), 1'b0, 8'h0, 2'd0, 32'h0);

      // R3, R5: all ones in the top lane, only the defined functions strobe
      wr(8'h09, 2'd3, 32'hFFFF_FFFF);
      step("R3 R5 top lane ones", 1'b1, 8'h09, 1'b0, 8'h0, 2'd0, 32'h0);

      // R4: groups and generator limit
      wr(8'h05, 2'd0, 32'hFFFF_FFFF);
      step("R4 trig all", 1'b1, 8'h05, 1'b0, 8'h0, 2'd0, 32'h0);
      wr(8'h06, 2'd1, 32'h0080_0001);
      wr(8'h06, 2'd2, 32'h8000_0002);
      step("R4 set clr", 1'b1, 8'h06, 1'b0, 8'h0, 2'd0, 32'h0);

      // R7: lane write leaves the other lanes alone
      wr(8'h05, 2'd2, 32'h0000_0F0F);
      step("R7 lane keep", 1'b1, 8'h05, 1'b0, 8'h0, 2'd0, 32'h0);

      // R6: code 0 silent even when loaded
      for (int l = 0; l < 4; l++) wr(8'h00, 2'(l), 32'hFFFF_FFFF);
      step("R6 code zero", 1'b1, 8'h00, 1'b0, 8'h0, 2'd0, 32'h0);

      // R9: invalid lookup of a loaded code
      step("R9 valid low", 1'b0, 8'h09, 1'b0, 8'h0, 2'd0, 32'h0);

      // R8: same-cycle write to the looked-up entry
      step("R8 old data", 1'b1, 8'h7A, 1'b1, 8'h7A, 2'd3, 32'h0);
      step("R8 new data", 1'b1, 8'h7A, 1'b0, 8'h0, 2'd0, 32'h0);

      // R2: back-to-back lookups then idle
      step("R2 b2b a", 1'b1, 8'h09, 1'b0, 8'h0, 2'd0, 32'h0);
      step("R2 b2b b", 1'b1, 8'h70, 1'b0, 8'h0, 2'd0, 32'h0);
      step("R2 idle after", 1'b0, 8'h70, 1'b0, 8'h0, 2'd0, 32'h0);

      // random mix over a small code window to force collisions (R2 R4 R7 R8)
      for (int n = 0; n < 2000; n++) begin
         logic [7:0] c, wc;
         c  = 8'($urandom_range(0, 15)) + ((($urandom & 1) != 0) ? 8'h70 : 8'h00);
         wc = ((($urandom & 3) == 0) ? c : 8'($urandom_range(0, 15)) + 8'h70);
         step("R2 R4 random", ($urandom % 4) != 0, c, ($urandom % 3) == 0, wc,
              2'($urandom), $urandom);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule